// File: doc/BRIEF.md
# Reset-Hold Duration Meter

This block measures how long an active-low board reset line is held asserted. Firmware uses the result to tell a brief tap from a long factory-reset press. The line is first passed through a two-stage synchroniser into the reference clock domain. A small state machine then lets a saturating counter advance by one on each reference clock cycle while the line is low. At the default 25 MHz reference, one count is 40 ns, and the 29-bit default width covers roughly 21.4 s.

The counter keeps its value after the line is released, so firmware can read the hold time at any later point. A second press with no clear in between adds to the stored value. Once the counter reaches all ones it stays there. Software zeroes it by writing a word with the clear bit (bit 31) set. That bit takes effect on the write and is never stored. A clear always beats a count that falls in the same cycle.

The state machine has three states:
- `ST_IDLE`: the synchronised line is high, or the machine is waiting to start counting.
- `ST_COUNT`: the line is low and the counter is advancing.
- `ST_SAT`: the counter is at full scale and held there.

Its transitions are:
- IDLE→COUNT when the line is low and the counter is below full scale.
- IDLE→SAT when the line is low and the counter is already at full scale.
- COUNT→IDLE when the line is released.
- COUNT→SAT when the increment in progress reaches full scale.
- SAT→SAT while no clear arrives.
- Any state → COUNT or IDLE on a clear, chosen by the current line level.

Top module: `rst_hold_meter`

## Requirements
- R1: While `por_n` is low, and on the first cycles after it rises, `rd_data` reads zero and the state is `ST_IDLE`.
- R2: Each rising edge of `clk_ref` at which `sys_rst_n_in` is sampled low adds exactly one to the count. That increment shows on `rd_data` after the third rising edge that follows the sample, which is one cycle in each of the two synchroniser stages plus the state register.
- R3: While the synchronised line is high, or the machine is in `ST_IDLE`, the count does not change.
- R4: After the line is released, the count keeps its value indefinitely until a clear.
- R5: A new low period that starts without a clear in between continues from the stored value.
- R6: A write (`wr_en` high) whose `wr_data` bit 31 is 1 sets the count to zero at that clock edge.
- R7: A write whose `wr_data` bit 31 is 0 has no effect on the count, whatever the other bits hold.
- R8: `rd_data` carries the count in bits CNT_W-1:0, and every bit above it reads zero.
- R9: The count stops at 2^CNT_W-1 and never wraps.
- R10: When a clear and an increment fall on the same edge, the result is zero.
- R11: `ST_SAT` is held until a clear arrives, even across a release and a new press. `ST_COUNT` with the line high and no clear moves to `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock that the counter runs on |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| sys_rst_n_in | input | 1 | Asynchronous active-low board reset line being measured |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data; bit 31 requests a clear |
| rd_data | output | 32 | Register read data; count in the low bits, zero above |

## Verification
The assertions check on every cycle that:
- the counter never steps by more than one;
- it stays frozen whenever the state machine withholds the enable;
- it reads zero right after a clear;
- it never leaves full scale without a clear;
- the idle and saturated states keep their meaning.

The exact three-cycle latency from the pin to the register can only be shown by the bench's scenarios, which compare every cycle against a behavioural model. The same holds for accumulation across separate presses, clear priority in the same cycle, and the fact that a write without the clear bit changes nothing.

// File: rtl/rhm_pkg.sv
package rhm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_SAT   = 2'd2
    } hold_state_t;

endpackage

// File: rtl/rhm_sync.sv
module rhm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    // Resets to the idle level (high) so no false press is seen after power-on.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/rhm_counter.sv
module rhm_counter #(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             at_max,
    output logic             near_max
);

    localparam logic [CNT_W-1:0] MAX_VAL  = '1;
    localparam logic [CNT_W-1:0] NEAR_VAL = MAX_VAL - 1'b1;

    logic [CNT_W-1:0] cnt_q;

    assign at_max   = (cnt_q == MAX_VAL);
    assign near_max = (cnt_q == NEAR_VAL);
    assign cnt      = cnt_q;

    // Clear has priority over an increment on the same edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && !at_max) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (at_max && !clr) |=> at_max);

    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

    assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)));

    assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/rhm_fsm.sv
module rhm_fsm
    import rhm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        line_low,
    input  logic        clr,
    input  logic        at_max,
    input  logic        near_max,
    output logic        cnt_en,
    output hold_state_t state
);

    hold_state_t state_q, state_d;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = line_low ? ST_COUNT : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (line_low) begin
                        state_d = at_max ? ST_SAT : ST_COUNT;
                    end
                end
                ST_COUNT: begin
                    if (!line_low) begin
                        state_d = ST_IDLE;
                    end else if (near_max) begin
                        state_d = ST_SAT;
                    end
                end
                ST_SAT: begin
                    state_d = ST_SAT;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs.
    always_comb begin
        cnt_en = (state_q == ST_COUNT) && !clr;
        state  = state_q;
    end

    assert_idle_no_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !cnt_en);

    assert_sat_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAT && !clr) |=> (state_q == ST_SAT));

    assert_release_to_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && !line_low && !clr) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/rst_hold_meter.sv
module rst_hold_meter #(
    parameter int CNT_W    = 29,
    parameter int DATA_W   = 32,
    parameter int CLR_BIT  = 31,
    parameter int SYNC_LEN = 2
) (
    input  logic              clk_ref,
    input  logic              por_n,
    input  logic              sys_rst_n_in,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    import rhm_pkg::*;

    localparam int PAD_W = DATA_W - CNT_W;

    logic             line_n_sync;
    logic             line_low;
    logic             clr_req;
    logic             cnt_en;
    logic             at_max;
    logic             near_max;
    logic [CNT_W-1:0] cnt;
    hold_state_t      state;

    rhm_sync #(
        .STAGES (SYNC_LEN)
    ) u_sync (
        .clk      (clk_ref),
        .rst_n    (por_n),
        .async_in (sys_rst_n_in),
        .sync_out (line_n_sync)
    );

    assign line_low = !line_n_sync;
    // The clear bit acts only on the write itself; it is never stored.
    assign clr_req  = wr_en && wr_data[CLR_BIT];

    rhm_fsm u_fsm (
        .clk      (clk_ref),
        .rst_n    (por_n),
        .line_low (line_low),
        .clr      (clr_req),
        .at_max   (at_max),
        .near_max (near_max),
        .cnt_en   (cnt_en),
        .state    (state)
    );

    rhm_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk      (clk_ref),
        .rst_n    (por_n),
        .clr      (clr_req),
        .inc      (cnt_en),
        .cnt      (cnt),
        .at_max   (at_max),
        .near_max (near_max)
    );

    assign rd_data = {{PAD_W{1'b0}}, cnt};

    assert_sat_state_full_R9: assert property (@(posedge clk_ref) disable iff (!por_n)
        (state == ST_SAT) |-> at_max);

endmodule

// File: tb/rst_hold_meter_bench.sv
module rst_hold_meter_bench;

    localparam int CNT_W = 6;
    localparam int MAXV  = (1 << CNT_W) - 1;

    logic        clk = 1'b0;
    logic        por_n;
    logic        sys_n;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;

    int    tests = 0;
    int    fails = 0;
    int    model_cnt;
    logic [2:0] hist;
    bit    run_cmp = 1'b0;
    string cur_tag = "R3";

    always #10 clk = ~clk;

    rst_hold_meter #(
        .CNT_W (CNT_W)
    ) u_rst_hold_meter (
        .clk_ref      (clk),
        .por_n        (por_n),
        .sys_rst_n_in (sys_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data)
    );

    // Behavioural reference: a low sample adds one three edges later; clear wins.
    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            model_cnt = 0;
            hist      = 3'b000;
        end else begin
            if (wr_en && wr_data[31]) begin
                model_cnt = 0;
            end else if (hist[2] && model_cnt < MAXV) begin
                model_cnt = model_cnt + 1;
            end
            hist = {hist[1:0], ~sys_n};
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (por_n && run_cmp) begin
            chk(cur_tag, rd_data, 32'(model_cnt));
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [31:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        wait_n(1);
        wr_en   = 1'b0;
        wr_data = 32'h0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        por_n   = 1'b0;
        sys_n   = 1'b1;
        wr_en   = 1'b0;
        wr_data = 32'h0;
        wait_n(3);
        chk("R1 in reset", rd_data, 32'h0);
        por_n   = 1'b1;
        run_cmp = 1'b1;
        wait_n(5);
        chk("R1 after reset", rd_data, 32'h0);

        // R2: latency and count of a 10-cycle press
        cur_tag = "R2";
        sys_n = 1'b0;
        wait_n(1);
        chk("R2 latency edge1", rd_data, 32'h0);
        wait_n(2);
        chk("R2 latency edge3", rd_data, 32'h0);
        wait_n(1);
        chk("R2 first increment", rd_data, 32'h1);
        wait_n(6);
        sys_n = 1'b1;
        wait_n(3);
        chk("R2 ten samples", rd_data, 32'd10);
        cur_tag = "R4";
        wait_n(10);
        chk("R4 held after release", rd_data, 32'd10);
        chk("R3 no count while high", rd_data, 32'd10);

        // R7: write without the clear bit
        cur_tag = "R7";
        do_write(32'h7FFF_FFFF);
        chk("R7 write without clear bit", rd_data, 32'd10);
        wait_n(2);
        chk("R7 still unchanged", rd_data, 32'd10);

        // R5: accumulate across presses
        cur_tag = "R5";
        sys_n = 1'b0;
        wait_n(5);
        sys_n = 1'b1;
        wait_n(4);
        chk("R5 accumulated", rd_data, 32'd15);

        // R6: clear
        cur_tag = "R6";
        do_write(32'h8000_0000);
        chk("R6 cleared", rd_data, 32'h0);

        // R10: clear during active counting
        cur_tag = "R10";
        sys_n = 1'b0;
        wait_n(6);
        chk("R10 counting before clear", rd_data, 32'd3);
        do_write(32'hFFFF_FFFF);
        chk("R10 clear wins over increment", rd_data, 32'h0);
        wait_n(1);
        chk("R10 counting resumes", rd_data, 32'h1);
        sys_n = 1'b1;
        wait_n(4);

        // R9: saturation
        cur_tag = "R9";
        do_write(32'h8000_0000);
        sys_n = 1'b0;
        wait_n(80);
        chk("R9 saturated", rd_data, 32'(MAXV));
        sys_n = 1'b1;
        wait_n(4);
        chk("R9 held at max", rd_data, 32'(MAXV));
        chk("R8 upper bits zero", rd_data & ~32'(MAXV), 32'h0);

        // R11: saturated state persists across a new press
        cur_tag = "R11";
        sys_n = 1'b0;
        wait_n(8);
        chk("R11 stays saturated", rd_data, 32'(MAXV));
        sys_n = 1'b1;
        wait_n(4);
        do_write(32'h8000_0000);
        chk("R11 clear leaves saturation", rd_data, 32'h0);
        cur_tag = "R3";
        wait_n(5);
        chk("R3 idle after clear", rd_data, 32'h0);
        sys_n = 1'b0;
        wait_n(2);
        sys_n = 1'b1;
        wait_n(4);
        chk("R11 counts again after clear", rd_data, 32'd2);

        run_cmp = 1'b0;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule